// File: doc/BRIEF.md
# Bridge Configuration Register File with Interrupt Steering

This block holds the byte-wide configuration registers of a bus bridge. Software reaches them in two ways. The first is a direct configuration port that carries a function number, an 8-bit offset and write data. The second is a pair of I/O ports: one latches an index, and the other reads or writes the register that index selects. The indexed path only reaches the bridge-private window at offsets 0x80 to 0x9F. Each register keeps only the bits its own write mask allows. Identification bytes are fixed, and two status bits clear when a one is written to them.

Two steering bytes hold four nibbles. Each nibble has an enable bit and a 3-bit code that names an interrupt line. The block decodes these nibbles into four registered route outputs, each an IRQ number with a valid flag. One bit of a private register is exported to choose between the two configuration access mechanisms. The block does not decode bus cycles or forward transactions. It only holds the settings and presents them.

Top module: `brg_cfg_regfile`

## Requirements
- R1: A write to the index I/O port (default address 0xA8) latches the 8-bit index, which resets to 0x00. A read of that port returns the latched index.
- R2: The data I/O port (default 0xA9) reads and writes the private register at the latched index, but only when the index is in 0x80–0x9F. Outside that range, a data-port write changes nothing and a data-port read returns 0xFF. A read of any other I/O address returns 0xFF, and a write to any other I/O address has no effect.
- R3: A configuration access with a nonzero function number returns 0xFF on read and changes no register on write.
- R4: Offsets 0x00, 0x01, 0x02 and 0x03 read 0x06, 0x11, 0x05 and 0x05, and writes do not change them. Offsets that hold no register (0x05, 0x06, 0x08–0x7F, 0xA0–0xFF) read 0x00.
- R5: Offset 0x04 resets to 0x07. Only bit 6 can be written, and all its other bits keep their values.
- R6: At offset 0x07, writing 1 to bit 7 or bit 4 clears that bit, and all other write data has no effect. Nothing in the block sets these bits, so the byte reads 0x00.
- R7: Offset 0x80 keeps its lower nibble and takes the upper nibble of the written data. Offsets 0x82, 0x83, 0x86 and 0x93 store the written data ANDed with 0xDB, 0xF9, 0xEF and 0xE0.
- R8: Offsets 0x81, 0x84, 0x85, 0x87–0x92 and 0x94 store all eight bits. Every other offset in 0x80–0x9F ignores writes and reads 0x00.
- R9: After reset, offset 0x81 reads 0x01, 0x84 reads 0x03 and 0x93 reads 0x40. Every other offset in 0x80–0x9F reads 0x00.
- R10: `mech2_sel` equals bit 7 of offset 0x86. A value of 0 selects configuration mechanism 1 and a value of 1 selects mechanism 2.
- R11: Route n (0=A, 1=B, 2=C, 3=D) takes its nibble as follows: A from bits 3:0 of 0x91, B from bits 7:4 of 0x91, C from bits 3:0 of 0x90, D from bits 7:4 of 0x90. In a nibble, bit 3 enables the route and bits 2:0 map codes 0–7 to IRQ none, 5, 9, 10, 11, 14, 15, none. `route_vld[n]` is 1 only when the route is enabled and the code is not none. `route_irq[4n+3:4n]` gives the IRQ number, or 0 when the route is not valid.
- R12: The route outputs are registered. After a write is presented in cycle t, the outputs show the new steering value from the edge that ends cycle t+1, and not before.
- R13: Both paths write the same storage. If both write the private window in the same cycle, the configuration-port write is applied and the data-port write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_func | input | FUNC_W (3) | Function number of the configuration access |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational from func/addr) |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | IO_AW (16) | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational from address) |
| mech2_sel | output | 1 | 1 selects configuration mechanism 2, 0 selects mechanism 1 |
| route_irq | output | 16 | Four 4-bit IRQ numbers, route A in bits 3:0 |
| route_vld | output | 4 | Valid flag per route, route A in bit 0 |

## Verification
The masks are tested with random bytes written to every offset through both paths. These writes tell preserved bits apart from masked-to-zero bits and from ignored writes. Random indices are biased toward the window edges, and random function numbers are mixed in, so that the window gate and the function gate can be compared with accepted writes. The steering bytes are tested with all enable and code combinations, including the two "none" codes with the enable set. The route outputs are sampled one edge early as well as on time, which separates correct latency from combinational or late decoding. A directed same-cycle write from both paths pins down the priority rule.

// File: rtl/brg_cfg_pkg.sv
// Package: shared constants and per-offset tables for the bridge
// configuration register file. Offsets are relative to the private window.
package brg_cfg_pkg;

    localparam int unsigned WIN_REGS = 32;
    localparam int unsigned WIN_OW   = $clog2(WIN_REGS);
    localparam int unsigned ROUTES   = 4;
    localparam int unsigned IRQ_W    = 4;

    // Writable-bit mask of a private register, by window-relative offset.
    function automatic logic [7:0] win_mask(input int unsigned off);
        case (off)
            0:                      return 8'hF0;
            2:                      return 8'hDB;
            3:                      return 8'hF9;
            6:                      return 8'hEF;
            19:                     return 8'hE0;
            1, 4, 5, 7, 8, 9, 10, 11, 12, 13, 14, 15,
            16, 17, 18, 20:         return 8'hFF;
            default:                return 8'h00;
        endcase
    endfunction

    // Reset value of a private register, by window-relative offset.
    function automatic logic [7:0] win_rst(input int unsigned off);
        case (off)
            1:       return 8'h01;
            4:       return 8'h03;
            19:      return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/brg_idx_port.sv
// Module: index/data I/O port pair.
// Latches an index from the index port and turns data-port writes into
// window writes when the index lies in the private window. Assumes the
// window is the 32 offsets whose top three bits are 3'b100.
module brg_idx_port #(
    parameter int unsigned IO_AW     = 16,
    parameter logic [15:0] IDX_PORT  = 16'h00A8,
    parameter logic [15:0] DATA_PORT = 16'h00A9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    input  logic [7:0]       win_rdata,
    output logic [7:0]       idx_q,
    output logic             data_we,
    output logic [7:0]       io_rdata
);
    logic idx_sel, data_sel, idx_in_win;

    // Port address decode and window gate.
    always_comb begin
        idx_sel    = (io_addr == IDX_PORT[IO_AW-1:0]);
        data_sel   = (io_addr == DATA_PORT[IO_AW-1:0]);
        idx_in_win = (idx_q[7:5] == 3'b100);
        data_we    = io_wr && data_sel && idx_in_win;
    end

    // Index latch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= 8'h00;
        else if (io_wr && idx_sel)
            idx_q <= io_wdata;
    end

    // I/O read return.
    always_comb begin
        if (idx_sel)
            io_rdata = idx_q;
        else if (data_sel && idx_in_win)
            io_rdata = win_rdata;
        else
            io_rdata = 8'hFF;
    end
endmodule

// File: rtl/brg_win_regs.sv
// Module: private register window storage.
// One byte per offset, one write port, two read ports. Each byte keeps
// its masked-off bits at their current value; constant-masked bits fold
// away, so only writable bits cost a flop.
module brg_win_regs
    import brg_cfg_pkg::*;
#(
    parameter int unsigned N  = WIN_REGS,
    localparam int unsigned OW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [OW-1:0] woff,
    input  logic [7:0]    wdata,
    input  logic [OW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [OW-1:0] raddr_b,
    output logic [7:0]    rdata_b,
    output logic [N*8-1:0] regs_flat
);
    logic [7:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        localparam logic [7:0] MSK = win_mask(i);
        localparam logic [7:0] RST = win_rst(i);

        // Masked byte update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= RST;
            else if (we && (woff == OW'(i)))
                regs[i] <= (regs[i] & ~MSK) | (wdata & MSK);
        end

        assign regs_flat[i*8 +: 8] = regs[i];
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/brg_route_dec.sv
// Module: one interrupt steering nibble decoder.
// Maps {enable, code[2:0]} to a registered IRQ number and valid flag.
// Assumes a code of 0 or 7 means no line.
module brg_route_dec
    import brg_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       nib,
    output logic [IRQ_W-1:0] irq_q,
    output logic             vld_q
);
    logic [IRQ_W-1:0] irq_d;

    // Code to line number.
    always_comb begin
        case (nib[2:0])
            3'd1:    irq_d = IRQ_W'(5);
            3'd2:    irq_d = IRQ_W'(9);
            3'd3:    irq_d = IRQ_W'(10);
            3'd4:    irq_d = IRQ_W'(11);
            3'd5:    irq_d = IRQ_W'(14);
            3'd6:    irq_d = IRQ_W'(15);
            default: irq_d = '0;
        endcase
    end

    // Registered route output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= nib[3] && (irq_d != '0);
            irq_q <= nib[3] ? irq_d : '0;
        end
    end
endmodule

// File: rtl/brg_cfg_regfile.sv
// Module: bridge configuration register file (top).
// Serves the direct configuration port and the index/data I/O pair,
// holds header and private registers, decodes four interrupt routes
// and exports the mechanism select. Assumes a single function (0).
module brg_cfg_regfile
    import brg_cfg_pkg::*;
#(
    parameter int unsigned FUNC_W    = 3,
    parameter int unsigned IO_AW     = 16,
    parameter logic [15:0] IDX_PORT  = 16'h00A8,
    parameter logic [15:0] DATA_PORT = 16'h00A9,
    parameter logic [31:0] ID_BYTES  = 32'h0505_1106
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [FUNC_W-1:0]   cfg_func,
    input  logic [7:0]          cfg_addr,
    input  logic [7:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata,
    input  logic                io_wr,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    output logic                mech2_sel,
    output logic [ROUTES*IRQ_W-1:0] route_irq,
    output logic [ROUTES-1:0]   route_vld
);
    localparam int unsigned OW       = WIN_OW;
    localparam int unsigned OFF_MECH = 6;
    localparam int unsigned OFF_STC  = 16;
    localparam logic [7:0]  CMD_FIX  = 8'h07;
    localparam logic [7:0]  STAT_W1C = 8'h90;

    logic          cfg_f0, cfg_in_win, cfg_win_we, io_win_we;
    logic          win_we;
    logic [OW-1:0] win_woff;
    logic [7:0]    win_wdata, win_rd_cfg, win_rd_io;
    logic [7:0]    idx_q;
    logic [WIN_REGS*8-1:0] regs_flat;
    logic          cmd_b6;
    logic [7:0]    stat_q;

    // Configuration access qualification.
    always_comb begin
        cfg_f0     = (cfg_func == '0);
        cfg_in_win = (cfg_addr[7:5] == 3'b100);
        cfg_win_we = cfg_wr && cfg_f0 && cfg_in_win;
    end

    brg_idx_port #(
        .IO_AW(IO_AW), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
    ) u_idx (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .win_rdata(win_rd_io), .idx_q(idx_q),
        .data_we(io_win_we), .io_rdata(io_rdata)
    );

    // Window write arbitration: configuration port wins.
    always_comb begin
        win_we    = cfg_win_we || io_win_we;
        win_woff  = cfg_win_we ? cfg_addr[OW-1:0]  : idx_q[OW-1:0];
        win_wdata = cfg_win_we ? cfg_wdata         : io_wdata;
    end

    brg_win_regs #(.N(WIN_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(win_we), .woff(win_woff),
        .wdata(win_wdata), .raddr_a(cfg_addr[OW-1:0]), .rdata_a(win_rd_cfg),
        .raddr_b(idx_q[OW-1:0]), .rdata_b(win_rd_io), .regs_flat(regs_flat)
    );

    // Header command bit 6 and write-one-to-clear status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_b6 <= CMD_FIX[6];
            stat_q <= 8'h00;
        end else if (cfg_wr && cfg_f0) begin
            if (cfg_addr == 8'h04)
                cmd_b6 <= cfg_wdata[6];
            if (cfg_addr == 8'h07)
                stat_q <= stat_q & ~(cfg_wdata & STAT_W1C);
        end
    end

    // Configuration read return.
    always_comb begin
        if (!cfg_f0)
            cfg_rdata = 8'hFF;
        else if (cfg_in_win)
            cfg_rdata = win_rd_cfg;
        else begin
            case (cfg_addr)
                8'h00:   cfg_rdata = ID_BYTES[7:0];
                8'h01:   cfg_rdata = ID_BYTES[15:8];
                8'h02:   cfg_rdata = ID_BYTES[23:16];
                8'h03:   cfg_rdata = ID_BYTES[31:24];
                8'h04:   cfg_rdata = {CMD_FIX[7], cmd_b6, CMD_FIX[5:0]};
                8'h07:   cfg_rdata = stat_q;
                default: cfg_rdata = 8'h00;
            endcase
        end
    end

    assign mech2_sel = regs_flat[OFF_MECH*8 + 7];

    // Route n: A/B from steering byte 1, C/D from steering byte 0.
    for (genvar n = 0; n < ROUTES; n++) begin : g_route
        localparam int unsigned BYTE = OFF_STC + ((n < 2) ? 1 : 0);
        localparam int unsigned LSB  = BYTE*8 + (n % 2)*4;
        brg_route_dec u_dec (
            .clk(clk), .rst_n(rst_n), .nib(regs_flat[LSB +: 4]),
            .irq_q(route_irq[n*IRQ_W +: IRQ_W]), .vld_q(route_vld[n])
        );
    end
endmodule

// File: rtl/brg_cfg_regfile_chk.sv
// Checker: temporal properties of the bridge configuration register file,
// bound to the top module. Observes ports and the latched index.
module brg_cfg_regfile_chk #(
    parameter int unsigned FUNC_W    = 3,
    parameter int unsigned IO_AW     = 16,
    parameter logic [15:0] IDX_PORT  = 16'h00A8,
    parameter logic [15:0] DATA_PORT = 16'h00A9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [FUNC_W-1:0] cfg_func,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              io_wr,
    input logic [IO_AW-1:0]  io_addr,
    input logic [7:0]        io_rdata,
    input logic              mech2_sel,
    input logic [15:0]       route_irq,
    input logic [3:0]        route_vld,
    input logic [7:0]        idx
);
    // R1
    idx_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == IDX_PORT[IO_AW-1:0]) |-> (io_rdata == idx));

    // R2
    data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_addr == DATA_PORT[IO_AW-1:0]) && (idx[7:5] != 3'b100))
        |-> (io_rdata == 8'hFF));

    // R3
    func_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func != '0) |-> (cfg_rdata == 8'hFF));

    // R4
    id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_func == '0) && (cfg_addr == 8'h01)) |-> (cfg_rdata == 8'h11));

    // R6
    stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_func == '0) && (cfg_addr == 8'h07)) |-> (cfg_rdata == 8'h00));

    // R10
    mech_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_wr && (cfg_func == '0) && (cfg_addr == 8'h86)) &&
         !(io_wr && (io_addr == DATA_PORT[IO_AW-1:0]) && (idx == 8'h86)))
        |=> $stable(mech2_sel));

    // R12
    route_off_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_func == '0) && (cfg_addr == 8'h91) && !cfg_wdata[3])
        |=> ##1 !route_vld[0]);

    for (genvar n = 0; n < 4; n++) begin : g_rt
        // R11
        route_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            route_vld[n] |-> (route_irq[n*4 +: 4] inside {4'd5, 4'd9, 4'd10,
                                                         4'd11, 4'd14, 4'd15}));
        // R11
        route_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !route_vld[n] |-> (route_irq[n*4 +: 4] == 4'd0));
    end
endmodule

bind brg_cfg_regfile brg_cfg_regfile_chk #(
    .FUNC_W(FUNC_W), .IO_AW(IO_AW), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_func(cfg_func),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_wr(io_wr), .io_addr(io_addr), .io_rdata(io_rdata),
    .mech2_sel(mech2_sel), .route_irq(route_irq), .route_vld(route_vld),
    .idx(idx_q)
);

// File: tb/brg_cfg_regfile_bench.sv
`timescale 1ns/1ps
module brg_cfg_regfile_bench;
    localparam real CYC = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        mech2_sel;
    logic [15:0] route_irq;
    logic [3:0]  route_vld;

    int unsigned checks = 0;
    int unsigned fails  = 0;

    logic [7:0] m_win [32];
    logic       m_cmd6;
    logic [7:0] m_idx;

    always #(CYC/2) clk = ~clk;

    brg_cfg_regfile u_brg_cfg_regfile (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_func(cfg_func),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .mech2_sel(mech2_sel), .route_irq(route_irq),
        .route_vld(route_vld)
    );

    // Writable bits by absolute offset, from R7/R8.
    function automatic logic [7:0] b_mask(input logic [7:0] a);
        if (a == 8'h80) return 8'hF0;
        if (a == 8'h82) return 8'hDB;
        if (a == 8'h83) return 8'hF9;
        if (a == 8'h86) return 8'hEF;
        if (a == 8'h93) return 8'hE0;
        if (a == 8'h81 || a == 8'h84 || a == 8'h85 || a == 8'h94 ||
            (a >= 8'h87 && a <= 8'h92)) return 8'hFF;
        return 8'h00;
    endfunction

    // Reset values from R9.
    function automatic logic [7:0] b_rst(input logic [7:0] a);
        if (a == 8'h81) return 8'h01;
        if (a == 8'h84) return 8'h03;
        if (a == 8'h93) return 8'h40;
        return 8'h00;
    endfunction

    // Expected configuration read (R3, R4, R5, R6).
    function automatic logic [7:0] b_cfg(input logic [2:0] f, input logic [7:0] a);
        if (f != 0) return 8'hFF;
        if (a >= 8'h80 && a <= 8'h9F) return m_win[a[4:0]];
        case (a)
            8'h00: return 8'h06;
            8'h01: return 8'h11;
            8'h02: return 8'h05;
            8'h03: return 8'h05;
            8'h04: return {1'b0, m_cmd6, 6'h07};
            default: return 8'h00;
        endcase
    endfunction

    // Expected {vld, irq} of route n (R11).
    function automatic logic [4:0] b_route(input int n);
        logic [7:0] by;
        logic [3:0] nb;
        logic [3:0] q;
        by = (n < 2) ? m_win[17] : m_win[16];
        nb = (n % 2 == 1) ? by[7:4] : by[3:0];
        case (nb[2:0])
            3'd1: q = 4'd5;
            3'd2: q = 4'd9;
            3'd3: q = 4'd10;
            3'd4: q = 4'd11;
            3'd5: q = 4'd14;
            3'd6: q = 4'd15;
            default: q = 4'd0;
        endcase
        if (!nb[3] || q == 0) return 5'd0;
        return {1'b1, q};
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_win[i] = b_rst(8'h80 + 8'(i));
        m_cmd6 = 1'b0;
        m_idx  = 8'h00;
    endtask

    task automatic model_win(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] m;
        m = b_mask(a);
        m_win[a[4:0]] = (m_win[a[4:0]] & ~m) | (d & m);
    endtask

    task automatic cfg_write(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (f == 0) begin
            if (a >= 8'h80 && a <= 8'h9F) model_win(a, d);
            if (a == 8'h04) m_cmd6 = d[6];
        end
    endtask

    task automatic io_write(input logic [15:0] p, input logic [7:0] d);
        @(negedge clk);
        io_addr = p; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (p == 16'h00A8) m_idx = d;
        else if (p == 16'h00A9 && m_idx >= 8'h80 && m_idx <= 8'h9F) model_win(m_idx, d);
    endtask

    task automatic cfg_read_chk(input string r, input logic [2:0] f, input logic [7:0] a);
        cfg_func = f; cfg_addr = a;
        #1;
        chk(r, {24'd0, cfg_rdata}, {24'd0, b_cfg(f, a)});
    endtask

    task automatic io_read_chk(input string r, input logic [15:0] p);
        logic [7:0] e;
        io_addr = p;
        #1;
        if (p == 16'h00A8) e = m_idx;
        else if (p == 16'h00A9 && m_idx >= 8'h80 && m_idx <= 8'h9F) e = m_win[m_idx[4:0]];
        else e = 8'hFF;
        chk(r, {24'd0, io_rdata}, {24'd0, e});
    endtask

    // One more edge, then compare all route outputs (R12 latency, R11 decode).
    task automatic route_chk(input string r);
        @(negedge clk);
        #1;
        for (int n = 0; n < 4; n++) begin
            logic [4:0] e;
            e = b_route(n);
            chk(r, {27'd0, route_vld[n], route_irq[n*4 +: 4]}, {27'd0, e});
        end
        chk("R10", {31'd0, mech2_sel}, {31'd0, m_win[6][7]});
    endtask

    initial begin : watchdog
        #(CYC * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = 32'd20251;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R9, R4, R5, R6, R1
        for (int a = 0; a < 256; a++) cfg_read_chk("R9", 3'd0, 8'(a));
        io_read_chk("R1", 16'h00A8);
        io_read_chk("R2", 16'h00A9);
        chk("R10", {31'd0, mech2_sel}, 32'd0);
        chk("R11", {28'd0, route_vld}, 32'd0);

        // R4: ID bytes and empty offsets ignore writes
        cfg_write(3'd0, 8'h00, 8'hAA); cfg_read_chk("R4", 3'd0, 8'h00);
        cfg_write(3'd0, 8'h03, 8'h00); cfg_read_chk("R4", 3'd0, 8'h03);
        cfg_write(3'd0, 8'h40, 8'h5A); cfg_read_chk("R4", 3'd0, 8'h40);
        // R5: only bit 6 moves
        cfg_write(3'd0, 8'h04, 8'hFF); cfg_read_chk("R5", 3'd0, 8'h04);
        cfg_write(3'd0, 8'h04, 8'h00); cfg_read_chk("R5", 3'd0, 8'h04);
        // R6: W1C bits stay clear
        cfg_write(3'd0, 8'h07, 8'hFF); cfg_read_chk("R6", 3'd0, 8'h07);
        // R7: 0x80 keeps lower nibble
        cfg_write(3'd0, 8'h80, 8'hFF); cfg_read_chk("R7", 3'd0, 8'h80);
        // R3: nonzero function ignored
        cfg_write(3'd2, 8'h85, 8'h77); cfg_read_chk("R3", 3'd0, 8'h85);
        cfg_read_chk("R3", 3'd5, 8'h00);
        // R2: out-of-window index, edges of window
        io_write(16'h00A8, 8'h7F); io_write(16'h00A9, 8'h33);
        io_read_chk("R2", 16'h00A9); cfg_read_chk("R2", 3'd0, 8'h7F);
        io_write(16'h00A8, 8'hA0); io_write(16'h00A9, 8'h33);
        io_read_chk("R2", 16'h00A9);
        io_write(16'h00A8, 8'h9F); io_write(16'h00A9, 8'hFF);
        io_read_chk("R8", 16'h00A9);
        io_write(16'h0123, 8'h44); io_read_chk("R2", 16'h0123); io_read_chk("R1", 16'h00A8);

        // R12: steering latency, one edge early and on time
        cfg_write(3'd0, 8'h91, 8'h0A);
        #1;
        chk("R12", {31'd0, route_vld[0]}, 32'd0);
        route_chk("R12");
        cfg_write(3'd0, 8'h90, 8'hF8);
        route_chk("R11");

        // R13: same-cycle conflict, configuration port wins
        io_write(16'h00A8, 8'h85);
        @(negedge clk);
        cfg_func = 3'd0; cfg_addr = 8'h85; cfg_wdata = 8'hAA; cfg_wr = 1'b1;
        io_addr = 16'h00A9; io_wdata = 8'h55; io_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; io_wr = 1'b0;
        model_win(8'h85, 8'hAA);
        io_read_chk("R13", 16'h00A9);

        // Random mixture
        for (int it = 0; it < 1500; it++) begin
            int unsigned op;
            logic [7:0] a, d;
            op = $urandom_range(0, 9);
            d  = 8'($urandom);
            if ($urandom_range(0, 2) == 0) a = 8'($urandom_range(16, 17) + 8'h80);
            else if ($urandom_range(0, 3) == 0) a = 8'($urandom);
            else a = 8'($urandom_range(8'h7E, 8'hA1));
            case (op)
                0, 1, 2, 3: cfg_write(3'd0, a, d);
                4:          cfg_write(3'($urandom_range(1, 7)), a, d);
                5, 6:       io_write(16'h00A8, a);
                7, 8:       io_write(16'h00A9, d);
                default:    io_write(16'($urandom_range(16'h00A0, 16'h00AF)), d);
            endcase
            cfg_read_chk("R7", 3'd0, a);
            io_read_chk("R2", 16'h00A9);
            if (it % 4 == 0) route_chk("R11");
        end

        // Reset again restores defaults: R9
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        for (int a = 8'h80; a < 8'hA0; a++) cfg_read_chk("R9", 3'd0, 8'(a));
        route_chk("R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule